// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave Port

This block lets an external 8-bit microcontroller reach a small bank of byte registers and a byte RAM over a bus that carries the low address byte and the data on the same eight wires. A separate bus carries the upper address byte. The block runs on a fast internal clock that is unrelated to the bus timing. The address-latch strobe and the active-low read and write strobes each pass through a synchronizer. The bus lines pass through a delay line of matching depth, so a value taken on a strobe edge is the value the bus held while the strobe was still at its old level.

The low address byte and the upper address byte are both taken when the address-latch strobe falls. The upper byte selects the block's window and then one of two spaces. A falling read strobe starts a read. A rising write strobe commits a write, using the data that was on the bus while the strobe was low. Each read and each write becomes a single-cycle internal request. Read data is driven through a separate output and an output-enable, for a bidirectional pad outside the block.

The microcontroller bus cannot be stalled, so the strobes are plain level pins with no valid/ready handshake. Timing closure relies on the bus keeping accesses at least six internal clocks apart. The block stays unready until reset has been held for a full count of internal clocks, and it ignores all accesses until then.

Top module: `mux_bus_slave`

## Requirements
- R1: `ready_o` is low while `rst_n` is low. After a low period of at least RST_HOLD (400) consecutive clock edges, `ready_o` is high from the first rising clock edge with `rst_n` high. After a shorter low period, `ready_o` stays low until a full-length reset occurs.
- R2: The low address byte is the value `ad_i` held at the last clock edge on which the latch strobe was sampled high before it fell. Values driven on `ad_i` from the fall onward do not change the latched address.
- R3: The upper address byte is latched at the same moment as the low byte. The port is selected when bits 7:1 of that byte equal CS_TAG (default 7'h40, so upper bytes 0x80 and 0x81).
- R4: A selected write commits on the rising edge of `wr_n_i`. The byte written is the one `ad_i` held while the strobe was low. Changing `ad_i` on the same clock as the rise has no effect on the written byte.
- R5: For a selected read, `ad_oe_o` goes high after the third rising clock edge that samples `rd_n_i` low, and goes low after the third rising edge that samples it high again. While `ad_oe_o` is high, `ad_o` holds the addressed byte and does not change.
- R6: With the latched upper byte outside the window, a read never raises `ad_oe_o` and a write changes no stored byte.
- R7: Bit 0 of the upper byte picks the space: 0 selects 16 registers at low addresses 0 to 15, and 1 selects a 256-byte RAM. In register space, low addresses 16 and above read as 0x00 and ignore writes. Registers clear to 0x00 on reset; the RAM keeps its contents.
- R8: While `ready_o` is low, reads never raise `ad_oe_o` and writes change nothing, including the RAM.
- R9: `ad_oe_o` is low out of reset and is high only during a selected read as timed in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset; its low time is counted |
| ale_i | input | 1 | Address-latch strobe, asynchronous |
| rd_n_i | input | 1 | Active-low read strobe, asynchronous |
| wr_n_i | input | 1 | Active-low write strobe, asynchronous |
| ahi_i | input | 8 | Upper address byte |
| ad_i | input | 8 | Multiplexed address/data bus, inbound |
| ad_o | output | 8 | Read data toward the bus pad |
| ad_oe_o | output | 1 | Output enable for the bus pad |
| ready_o | output | 1 | High once a full-length reset has completed |

## Verification
Most faults in this block show up first in `ad_oe_o`. A wrong synchronizer depth or a wrong edge polarity moves the enable edge off the third sampled edge, or drops it entirely, at the first read. A misaligned delay line or a wrong latch point lands a write in the wrong cell. That error only becomes visible at the next read of the affected address, when `ad_o` differs from the model. A counter that miscounts the reset hold shows as `ready_o` being wrong one cycle after release. A wrong window or space decode either drives the bus where it must stay silent, or returns a byte other than the one last written.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic {
    SPACE_REG = 1'b0,
    SPACE_RAM = 1'b1
  } space_e;

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] lo;
  } bus_word_t;

endpackage

// File: rtl/mbs_sync_edge.sv
module mbs_sync_edge #(
  parameter int STAGES      = 2,
  parameter bit RST_VAL     = 1'b1,
  parameter bit DETECT_RISE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic last_o,
  output logic edge_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      last_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign last_o  = last_q;

  generate
    if (DETECT_RISE) begin : g_rise
      assign edge_o = level_o & ~last_q;
    end else begin : g_fall
      assign edge_o = ~level_o & last_q;
    end
  endgenerate

  AST_SINGLE_CYCLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o); // R5

endmodule

// File: rtl/mbs_delay.sv
module mbs_delay #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o
);

  logic [WIDTH-1:0] stage_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [WIDTH-1:0] feed;
    logic [WIDTH-1:0] q;
    if (g == 0) begin : g_head
      assign feed = d_i;
    end else begin : g_body
      assign feed = stage_w[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= feed;
    end
    assign stage_w[g] = q;
  end

  assign d_o = stage_w[DEPTH-1];

endmodule

// File: rtl/mbs_reset_hold.sv
module mbs_reset_hold #(
  parameter int HOLD = 400
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready_o
);

  localparam int            CW     = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          rst_seen_q;
  logic          ready_q;

  always_comb begin
    if (rst_n)            cnt_d = cnt_q;
    else if (rst_seen_q)  cnt_d = ONE_C;
    else if (cnt_q >= HOLD_C) cnt_d = HOLD_C;
    else                  cnt_d = cnt_q + ONE_C;
  end

  always_ff @(posedge clk) begin
    rst_seen_q <= rst_n;
    cnt_q      <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= (cnt_q == HOLD_C);
  end

  assign ready_o = ready_q;

  AST_READY_AFTER_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> ($past(cnt_q) == HOLD_C)); // R1

endmodule

// File: rtl/mbs_store.sv
module mbs_store
  import mbs_pkg::*;
#(
  parameter int REG_NUM   = 16,
  parameter int RAM_DEPTH = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic       re_i,
  input  space_e     space_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);

  localparam int         REG_AW  = $clog2(REG_NUM);
  localparam int         RAM_AW  = $clog2(RAM_DEPTH);
  localparam logic [8:0] REG_LIM = 9'(REG_NUM);
  localparam logic [8:0] RAM_LIM = 9'(RAM_DEPTH);

  logic [7:0] reg_view [REG_NUM];
  logic [7:0] ram_q    [RAM_DEPTH];
  logic [7:0] rd_val;
  logic [7:0] rdata_q;
  logic       reg_hit;
  logic       ram_hit;

  assign reg_hit = (space_i == SPACE_REG) && ({1'b0, addr_i} < REG_LIM);
  assign ram_hit = (space_i == SPACE_RAM) && ({1'b0, addr_i} < RAM_LIM);

  for (genvar r = 0; r < REG_NUM; r++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    q <= 8'h00;
      else if (we_i && reg_hit && addr_i == 8'(r))  q <= wdata_i;
    end
    assign reg_view[r] = q;
  end

  always_ff @(posedge clk) begin
    if (we_i && ram_hit) ram_q[addr_i[RAM_AW-1:0]] <= wdata_i;
  end

  always_comb begin
    if (reg_hit)      rd_val = reg_view[addr_i[REG_AW-1:0]];
    else if (ram_hit) rd_val = ram_q[addr_i[RAM_AW-1:0]];
    else              rd_val = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= 8'h00;
    else if (re_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave
  import mbs_pkg::*;
#(
  parameter logic [6:0] CS_TAG      = 7'h40,
  parameter int         REG_NUM     = 16,
  parameter int         RAM_DEPTH   = 256,
  parameter int         SYNC_STAGES = 2,
  parameter int         RST_HOLD    = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ale_i,
  input  logic       rd_n_i,
  input  logic       wr_n_i,
  input  logic [7:0] ahi_i,
  input  logic [7:0] ad_i,
  output logic [7:0] ad_o,
  output logic       ad_oe_o,
  output logic       ready_o
);

  localparam int PIPE_DEPTH = SYNC_STAGES + 1;
  localparam int WORD_W     = $bits(bus_word_t);

  logic rd_lvl, rd_last, rd_fall;
  logic wr_unused_lvl, wr_unused_last, wr_rise;
  logic ale_unused_lvl, ale_unused_last, ale_fall;

  mbs_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .DETECT_RISE(1'b0)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .async_i(rd_n_i),
    .level_o(rd_lvl), .last_o(rd_last), .edge_o(rd_fall)
  );

  mbs_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .DETECT_RISE(1'b1)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .async_i(wr_n_i),
    .level_o(wr_unused_lvl), .last_o(wr_unused_last), .edge_o(wr_rise)
  );

  mbs_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .DETECT_RISE(1'b0)) u_ale_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ale_i),
    .level_o(ale_unused_lvl), .last_o(ale_unused_last), .edge_o(ale_fall)
  );

  bus_word_t bus_now;
  bus_word_t bus_d;
  bus_word_t addr_q;

  assign bus_now.hi = ahi_i;
  assign bus_now.lo = ad_i;

  mbs_delay #(.WIDTH(WORD_W), .DEPTH(PIPE_DEPTH)) u_bus_dly (
    .clk(clk), .rst_n(rst_n), .d_i(bus_now), .d_o(bus_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr_q <= '0;
    else if (ale_fall) addr_q <= bus_d;
  end

  logic ready_w;

  mbs_reset_hold #(.HOLD(RST_HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n), .ready_o(ready_w)
  );

  logic   cs_w, go_w, rd_req, wr_req;
  space_e space_w;

  assign cs_w    = (addr_q.hi[7:1] == CS_TAG);
  assign go_w    = cs_w & ready_w;
  assign rd_req  = rd_fall & go_w;
  assign wr_req  = wr_rise & go_w;
  assign space_w = space_e'(addr_q.hi[0]);

  mbs_store #(.REG_NUM(REG_NUM), .RAM_DEPTH(RAM_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we_i(wr_req), .re_i(rd_req), .space_i(space_w),
    .addr_i(addr_q.lo), .wdata_i(bus_d.lo), .rdata_o(ad_o)
  );

  logic oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= rd_req | (oe_q & ~rd_lvl);
  end

  assign ad_oe_o = oe_q;
  assign ready_o = ready_w;

  AST_OE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_o |-> cs_w); // R6

  AST_OE_NOT_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> !ad_oe_o); // R8

  AST_OE_INSIDE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_o |-> !rd_last); // R9

  AST_RDATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe_o && $past(ad_oe_o)) |-> $stable(ad_o)); // R5

endmodule

// File: tb/mux_bus_slave_tb.sv
module mux_bus_slave_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ale_i, rd_n_i, wr_n_i;
  logic [7:0] ahi_i, ad_i;
  logic [7:0] ad_o;
  logic       ad_oe_o, ready_o;

  always #2 clk = ~clk;

  mux_bus_slave u_dut (
    .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
    .ahi_i(ahi_i), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ready_o(ready_o)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // behavioural reference model
  logic [7:0] regs_m [16];
  logic [7:0] ram_m  [256];
  logic [7:0] hi_m, lo_m;
  bit         rdy_m  = 0;
  bit         cmp_en = 0;
  bit         exp_oe = 0;
  bit         rd_h1 = 1, rd_h2 = 1, rd_h3 = 1;

  function automatic bit cs_m();
    return hi_m[7:1] == 7'h40;
  endfunction

  function automatic logic [7:0] model_rd();
    if (hi_m[0] == 1'b0) return (lo_m < 8'd16) ? regs_m[lo_m[3:0]] : 8'h00;
    return ram_m[lo_m];
  endfunction

  task automatic clear_regs_m();
    for (int i = 0; i < 16; i++) regs_m[i] = 8'h00;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_h1 <= 1; rd_h2 <= 1; rd_h3 <= 1; exp_oe <= 0;
    end else begin
      exp_oe <= !rd_h2 && (exp_oe || (rd_h3 && cs_m() && rdy_m));
      rd_h1 <= rd_n_i; rd_h2 <= rd_h1; rd_h3 <= rd_h2;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(ad_oe_o === exp_oe, "R9", "per-cycle enable", ad_oe_o, exp_oe);
      if (exp_oe) chk(ad_o === model_rd(), "R5", "per-cycle data", ad_o, model_rd());
    end
  end

  task automatic latch_addr(input logic [7:0] hi, input logic [7:0] lo);
    ale_i = 1; ahi_i = hi; ad_i = lo;
    repeat (2) @(negedge clk);
    ale_i = 0; ahi_i = ~hi; ad_i = ~lo;
    repeat (4) @(negedge clk);
    hi_m = hi; lo_m = lo;
  endtask

  task automatic bus_write(input logic [7:0] d);
    ad_i = d; wr_n_i = 0;
    repeat (4) @(negedge clk);
    wr_n_i = 1; ad_i = ~d;
    repeat (4) @(negedge clk);
    if (cs_m() && rdy_m) begin
      if (hi_m[0] == 1'b0) begin
        if (lo_m < 8'd16) regs_m[lo_m[3:0]] = d;
      end else ram_m[lo_m] = d;
    end
  endtask

  task automatic bus_read(input string req);
    bit         inwin;
    logic [7:0] e;
    inwin = cs_m() && rdy_m;
    e = model_rd();
    rd_n_i = 0;
    repeat (2) @(negedge clk);
    chk(ad_oe_o == 1'b0, "R5", "enable before third edge", ad_oe_o, 0);
    @(negedge clk);
    chk(ad_oe_o == inwin, req, "enable at third edge", ad_oe_o, inwin);
    if (inwin) chk(ad_o == e, req, "read data", ad_o, e);
    repeat (3) @(negedge clk);
    rd_n_i = 1;
    repeat (2) @(negedge clk);
    chk(ad_oe_o == inwin, "R5", "enable held after release", ad_oe_o, inwin);
    @(negedge clk);
    chk(ad_oe_o == 1'b0, "R5", "enable dropped", ad_oe_o, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst_n = 0; rdy_m = 0; clear_regs_m();
    repeat (n) @(negedge clk);
    chk(ready_o == 1'b0, "R1", "ready during reset", ready_o, 0);
    chk(ad_oe_o == 1'b0, "R9", "enable during reset", ad_oe_o, 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; ale_i = 0; rd_n_i = 1; wr_n_i = 1; ahi_i = 0; ad_i = 0;
    hi_m = 0; lo_m = 0; clear_regs_m();
    for (int i = 0; i < 256; i++) ram_m[i] = 8'h00;
    repeat (450) @(negedge clk);
    chk(ready_o == 1'b0, "R1", "ready during initial reset", ready_o, 0);
    chk(ad_oe_o == 1'b0, "R9", "enable in reset", ad_oe_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk(ready_o == 1'b1, "R1", "ready after long reset", ready_o, 1);
    rdy_m = 1; cmp_en = 1;

    // register reset value and space decode
    latch_addr(8'h80, 8'h03); bus_read("R7");
    // fill RAM cells used later
    for (int i = 0; i < 4; i++) begin
      latch_addr(8'h81, 8'(i * 8'h40 + 8'h11)); bus_write(8'(8'hA0 + i));
    end
    // register writes and read back (R2 low byte, R3 window, R4 data)
    latch_addr(8'h80, 8'h03); bus_write(8'h5A);
    latch_addr(8'h80, 8'h0F); bus_write(8'hC3);
    latch_addr(8'h81, 8'h00); bus_write(8'h11);
    latch_addr(8'h81, 8'hFF); bus_write(8'hEE);
    latch_addr(8'h81, 8'h42); bus_write(8'h77);
    latch_addr(8'h80, 8'h03); bus_read("R4");
    latch_addr(8'h80, 8'h0F); bus_read("R2");
    latch_addr(8'h81, 8'h00); bus_read("R3");
    latch_addr(8'h81, 8'hFF); bus_read("R7");
    latch_addr(8'h81, 8'h42); bus_read("R4");
    for (int i = 0; i < 4; i++) begin
      latch_addr(8'h81, 8'(i * 8'h40 + 8'h11)); bus_read("R2");
    end
    // register space beyond the bank
    latch_addr(8'h80, 8'h14); bus_write(8'h33);
    latch_addr(8'h80, 8'h14); bus_read("R7");
    latch_addr(8'h80, 8'h04); bus_read("R7");
    // outside the window: upper byte 0x82 aliases no cell
    latch_addr(8'h82, 8'h03); bus_write(8'h99);
    latch_addr(8'h82, 8'h03); bus_read("R6");
    latch_addr(8'h7F, 8'h42); bus_write(8'h99);
    latch_addr(8'h7F, 8'h42); bus_read("R6");
    latch_addr(8'h80, 8'h03); bus_read("R6");
    latch_addr(8'h81, 8'h42); bus_read("R6");

    // short reset: one edge short of the hold count
    do_reset(399);
    repeat (4) @(negedge clk);
    chk(ready_o == 1'b0, "R1", "ready after short reset", ready_o, 0);
    latch_addr(8'h81, 8'h42); bus_write(8'h44);
    latch_addr(8'h81, 8'h42); bus_read("R8");
    latch_addr(8'h80, 8'h02); bus_write(8'h66);

    // full reset restores operation; RAM kept its old byte
    do_reset(400);
    chk(ready_o == 1'b1, "R1", "ready after exact hold", ready_o, 1);
    rdy_m = 1;
    latch_addr(8'h81, 8'h42); bus_read("R8");
    latch_addr(8'h80, 8'h03); bus_read("R7");
    latch_addr(8'h80, 8'h02); bus_read("R8");
    latch_addr(8'h80, 8'h07); bus_write(8'h3C);
    latch_addr(8'h80, 8'h07); bus_read("R4");

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule